// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Vector Generation

This block takes a vector of pending interrupt inputs and one configuration word per input, and picks the single input that should be serviced. The choice depends on the level each input asks for. For the winning input it builds a request packet for the processor: a handler address, a register-set number, the level and a non-maskable flag. Alongside the packet it raises one request line. It also produces a status word that names the winner, and a copy of the vector address, both meant for a register file that sits elsewhere.

The handler address is found in a vector table. The table starts at a programmable base, and each of its entries is a power of two in size. A 3-bit selector sets that size, from 4 bytes up to 512 bytes. Selection is a balanced comparison tree. A small two-state machine tracks whether a request is being presented. The state is IDLE when no request is presented and ACTIVE while one is. Three transitions are named: RAISE (IDLE to ACTIVE), DROP (ACTIVE to IDLE) and RETARGET (ACTIVE to ACTIVE, possibly with a new winner). All outputs are registered.

Top module: `vic_arb`

## Requirements
- R1: Each 13-bit configuration word carries the level in bits [5:0], the non-maskable flag in bit 6 and the register set in bits [12:7]. The packet reports these fields for the winning input.
- R2: Among inputs whose pending bit is 1, the input with the strictly greatest level wins.
- R3: When two inputs tie on level, the input with the lower index wins.
- R4: An input with level 0, or one that is not pending, never wins. When no input qualifies, `req` is 0 and all packet fields are 0.
- R5: The vector table entry size in bytes is 1 << (2 + `size_sel`).
- R6: The handler address is the winning index times the entry size, plus `table_base`, taken modulo 2^32. `vec_addr` carries the same value.
- R7: `status_word` holds the winning index in bits [4:0] and has bit 31 set. When nothing wins, `status_word` is 0 and `vec_addr` is 0.
- R8: Reset clears every output to 0. Each output reflects the inputs sampled at the previous rising clock edge.
- R9: While `req` is 1 and the inputs do not change, all packet fields hold steady.
- R10: The state is ACTIVE exactly when a winner exists. `req` is 1 exactly when the state is ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pending | input | 32 | Pending interrupt vector |
| irq_cfg | input | 416 | Configuration words; input i occupies bits [13*i+12:13*i] |
| size_sel | input | 3 | Selects the vector entry size |
| table_base | input | 32 | Vector table base address |
| req | output | 1 | Interrupt request to the processor |
| req_addr | output | 32 | Handler address |
| req_regset | output | 6 | Register set requested |
| req_level | output | 6 | Level requested |
| req_nmi | output | 1 | Non-maskable flag |
| status_word | output | 32 | Winner index with a valid flag in bit 31 |
| vec_addr | output | 32 | Vector address of the winner |

## Verification
The hardest case to reach from the ports is a multi-way tie on the greatest level. Here the tree must carry the left-hand candidate through every stage, including stages where the tied inputs sit in different subtrees. To reach it, the random stimulus mostly draws levels from a range of only four values, so ties among many pending inputs happen often. Directed cases add a tie across the two halves of the vector and a maximum-index winner whose address wraps past 2^32.

// File: rtl/vic_arb_pkg.sv
package vic_arb_pkg;
    localparam int LVL_W = 6;
    localparam int RS_W  = 6;
    localparam int CFG_W = LVL_W + 1 + RS_W;
    localparam int SEL_W = 3;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } arb_state_t;

    typedef struct packed {
        logic [RS_W-1:0]  regset;
        logic             nmi;
        logic [LVL_W-1:0] level;
    } cfg_word_t;
endpackage

// File: rtl/vic_lvl_tree.sv
module vic_lvl_tree #(
    parameter int N  = 32,
    parameter int LW = 6,
    parameter int IW = $clog2(N)
) (
    input  logic [N*LW-1:0] lvl_in,
    output logic [LW-1:0]   win_lvl,
    output logic [IW-1:0]   win_idx
);
    // Heap-ordered nodes: node k has children 2k (lower indices) and 2k+1.
    logic [LW-1:0] node_lvl [1:2*N-1];
    logic [IW-1:0] node_idx [1:2*N-1];

    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign node_lvl[N+i] = lvl_in[i*LW +: LW];
        assign node_idx[N+i] = IW'(i);
    end

    for (genvar k = 1; k < N; k++) begin : g_node
        logic take_right;
        assign take_right  = node_lvl[2*k+1] > node_lvl[2*k];
        assign node_lvl[k] = take_right ? node_lvl[2*k+1] : node_lvl[2*k];
        assign node_idx[k] = take_right ? node_idx[2*k+1] : node_idx[2*k];
    end

    assign win_lvl = node_lvl[1];
    assign win_idx = node_idx[1];
endmodule

// File: rtl/vic_vec_gen.sv
module vic_vec_gen #(
    parameter int IW     = 5,
    parameter int SW     = 3,
    parameter int ADDR_W = 32
) (
    input  logic [IW-1:0]     idx,
    input  logic [SW-1:0]     size_sel,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] offset;
    int unsigned       shamt;

    always_comb begin
        shamt  = 32'(size_sel) + 32'd2;
        offset = ADDR_W'(idx) << shamt;
        addr   = base + offset;
    end
endmodule

// File: rtl/vic_arb.sv
module vic_arb
    import vic_arb_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IRQ-1:0]       irq_pending,
    input  logic [NUM_IRQ*CFG_W-1:0] irq_cfg,
    input  logic [SEL_W-1:0]         size_sel,
    input  logic [ADDR_W-1:0]        table_base,
    output logic                     req,
    output logic [ADDR_W-1:0]        req_addr,
    output logic [RS_W-1:0]          req_regset,
    output logic [LVL_W-1:0]         req_level,
    output logic                     req_nmi,
    output logic [31:0]              status_word,
    output logic [ADDR_W-1:0]        vec_addr
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic [NUM_IRQ*LVL_W-1:0] masked_lvl;
    logic [LVL_W-1:0]         win_lvl;
    logic [IDX_W-1:0]         win_idx;
    logic [ADDR_W-1:0]        win_addr;
    cfg_word_t                win_cfg;
    logic                     found;
    arb_state_t               state_q, state_d;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
        cfg_word_t w;
        assign w = cfg_word_t'(irq_cfg[i*CFG_W +: CFG_W]);
        assign masked_lvl[i*LVL_W +: LVL_W] = irq_pending[i] ? w.level : '0;
    end

    vic_lvl_tree #(.N(NUM_IRQ), .LW(LVL_W), .IW(IDX_W)) u_tree (
        .lvl_in  (masked_lvl),
        .win_lvl (win_lvl),
        .win_idx (win_idx)
    );

    vic_vec_gen #(.IW(IDX_W), .SW(SEL_W), .ADDR_W(ADDR_W)) u_vec (
        .idx      (win_idx),
        .size_sel (size_sel),
        .base     (table_base),
        .addr     (win_addr)
    );

    assign win_cfg = cfg_word_t'(irq_cfg[win_idx*CFG_W +: CFG_W]);
    assign found   = win_lvl != '0;

    // Next state: RAISE, DROP, RETARGET or stay idle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (found)  state_d = ST_ACTIVE;  // RAISE
            ST_ACTIVE: if (!found) state_d = ST_IDLE;    // DROP, else RETARGET
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered packet and status, loaded for the state being entered.
    always_ff @(posedge clk) begin
        if (!rst_n || state_d == ST_IDLE) begin
            req_addr    <= '0;
            req_regset  <= '0;
            req_level   <= '0;
            req_nmi     <= 1'b0;
            status_word <= '0;
            vec_addr    <= '0;
        end else begin
            req_addr    <= win_addr;
            req_regset  <= win_cfg.regset;
            req_level   <= win_lvl;
            req_nmi     <= win_cfg.nmi;
            status_word <= {1'b1, (31-IDX_W)'(0), win_idx};
            vec_addr    <= win_addr;
        end
    end

    assign req = state_q == ST_ACTIVE;
endmodule

// File: rtl/vic_arb_chk.sv
module vic_arb_chk
    import vic_arb_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_IRQ-1:0]       irq_pending,
    input logic [NUM_IRQ*CFG_W-1:0] irq_cfg,
    input logic [SEL_W-1:0]         size_sel,
    input logic [ADDR_W-1:0]        table_base,
    input logic                     req,
    input logic [ADDR_W-1:0]        req_addr,
    input logic [RS_W-1:0]          req_regset,
    input logic [LVL_W-1:0]         req_level,
    input logic                     req_nmi,
    input logic [31:0]              status_word,
    input logic [ADDR_W-1:0]        vec_addr
);
    AST_REQ_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> req_level != '0); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (status_word == '0 && vec_addr == '0 && req_addr == '0)); // R7
    AST_STATUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        req == status_word[31]); // R10
    AST_ADDR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        req_addr == vec_addr); // R6
    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (($past(irq_pending) >> status_word[4:0]) & 1) != 0); // R2
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(req) && $past(irq_pending) == $past(irq_pending, 2)
         && $past(irq_cfg) == $past(irq_cfg, 2) && $past(size_sel) == $past(size_sel, 2)
         && $past(table_base) == $past(table_base, 2))
        |-> ($stable(req_addr) && $stable(req_level) && $stable(req_regset)
             && $stable(req_nmi) && $stable(status_word))); // R9
endmodule

bind vic_arb vic_arb_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_vic_arb.sv
module sim_vic_arb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  irq_pending = '0;
    logic [415:0] irq_cfg = '0;
    logic [2:0]   size_sel = '0;
    logic [31:0]  table_base = '0;
    logic         req;
    logic [31:0]  req_addr, status_word, vec_addr;
    logic [5:0]   req_regset, req_level;
    logic         req_nmi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vic_arb u0 (.*);

    function automatic logic [12:0] cfg_of(int i);
        return irq_cfg[i*13 +: 13];
    endfunction

    function automatic int ref_winner();
        int best = 0;
        int idx = -1;
        for (int i = 0; i < 32; i++) begin
            int lv = int'(cfg_of(i) & 13'h3f);
            if (irq_pending[i] && lv > best) begin
                best = lv;
                idx = i;
            end
        end
        return idx;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        int w = ref_winner();
        logic [31:0] e_addr, e_stat;
        logic [12:0] c;
        if (w < 0) begin
            chk(req == 1'b0, {tag, " R4 req"}, 32'(req), 0);
            chk(status_word == 0, {tag, " R7 status"}, status_word, 0);
            chk(vec_addr == 0, {tag, " R7 vec"}, vec_addr, 0);
            chk(req_level == 0 && req_nmi == 0 && req_regset == 0,
                {tag, " R4 packet"}, {19'd0, req_nmi, req_regset, req_level}, 0);
        end else begin
            c = cfg_of(w);
            e_addr = table_base + 32'(w) * (32'd1 << (2 + size_sel));
            e_stat = 32'h8000_0000 | 32'(w);
            chk(req == 1'b1, {tag, " R10 req"}, 32'(req), 1);
            chk(status_word == e_stat, {tag, " R2 R3 R7 status"}, status_word, e_stat);
            chk(req_addr == e_addr, {tag, " R5 R6 addr"}, req_addr, e_addr);
            chk(vec_addr == e_addr, {tag, " R6 vec"}, vec_addr, e_addr);
            chk({req_regset, req_nmi, req_level} == c, {tag, " R1 fields"},
                32'({req_regset, req_nmi, req_level}), 32'(c));
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next fall.
    task automatic step(string tag);
        @(posedge clk);
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic set_cfg(int i, int lv, int nmi, int rs);
        irq_cfg[i*13 +: 13] = {6'(rs), 1'(nmi), 6'(lv)};
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk(req == 0 && status_word == 0 && vec_addr == 0 && req_addr == 0,
            "R8 reset", {31'd0, req}, 0);
        rst_n = 1'b1;
        step("idle");

        // All pending, all level zero: nothing may win.
        irq_pending = '1;
        for (int i = 0; i < 32; i++) set_cfg(i, 0, 1, 63);
        step("R4 all-zero-level");

        // Latency: change input, output must still show old value before the edge.
        set_cfg(9, 7, 1, 5);
        set_cfg(20, 7, 0, 9);
        #1 chk(req == 0, "R8 latency", 32'(req), 0);
        step("R3 tie across halves");

        // Higher level on a non-pending input is ignored.
        irq_pending = 32'h0010_0200;
        set_cfg(3, 60, 0, 1);
        step("R2 R4 not pending");

        // Max index, max entry size, address wraps.
        irq_pending = '1;
        set_cfg(31, 63, 1, 42);
        size_sel = 3'd7;
        table_base = 32'hFFFF_F000;
        step("R6 wrap");
        for (int k = 0; k < 3; k++) step("R9 hold");

        // Every entry size.
        for (int s = 0; s < 8; s++) begin
            size_sel = 3'(s);
            table_base = 32'h0000_1000;
            step("R5 size");
        end

        // DROP back to IDLE.
        irq_pending = '0;
        step("R10 drop");

        // Random stimulus, narrow level range favours ties.
        for (int t = 0; t < 400; t++) begin
            int narrow = ($urandom % 4) != 0;
            for (int i = 0; i < 32; i++)
                set_cfg(i, narrow ? int'($urandom % 4) : int'($urandom % 64),
                        int'($urandom % 2), int'($urandom % 64));
            irq_pending = $urandom & $urandom;
            size_sel = 3'($urandom);
            table_base = $urandom;
            step("random");
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule